// File: doc/BRIEF.md
# Quarter-Rate Bang-Bang Phase Detector

This block sits behind a bank of eight samplers driven by eight evenly spaced phases of a slow clock. Each slow-clock cycle it is handed one window of eight samples of a serial bit stream covering four bit periods. Samples alternate between bit centres and bit boundaries. The block turns the four centre samples into a 4-bit parallel word, which demultiplexes the stream 1:4. It also compares each pair of neighbouring samples to decide, at every data transition, whether the sampling clock is early or late.

The four per-edge decisions are summed into a signed net phase error and into up/down flags that drive a loop filter. A window that contains no transition produces exactly zero error, so the downstream oscillator control stays where it is. The edge that straddles two windows is judged with the last centre and edge samples of the previous window, which are kept in a small boundary register. With that register all four edges of every window are evaluated. All outputs are registered and have one slow-clock cycle of latency.

Top module: `qpd_top`

## Requirements
- R1: `samples_i[2k]` is the centre sample of bit k of the window, where bit 0 is the earliest. One cycle after a window is presented, `data_o[k]` equals `samples_i[2k]`.
- R2: `samples_i[2k+1]` is the edge sample between bit k and bit k+1. For an edge with preceding centre A, edge sample E and following centre B: if A equals B there is no vote; otherwise a vote is late (+1) when E differs from A and early (-1) when E equals A.
- R3: The edge ahead of bit 0 is judged with A equal to the previous window's `samples_i[2*LANES-2]`, E equal to its `samples_i[2*LANES-1]`, and B equal to the current `samples_i[0]`.
- R4: `err_o` is the two's-complement sum of late votes minus early votes over the four edges of a window, in the range -4 to +4. It appears one cycle after the window is presented.
- R5: In a window where all centre samples equal the previous window's last centre sample, `err_o` is zero whatever the edge samples are.
- R6: `up_o` is high exactly when `err_o` is positive and `dn_o` exactly when it is negative. They are never high together.
- R7: Reset is synchronous and active-low. It clears `data_o`, `err_o`, `up_o`, `dn_o` and both boundary samples to zero, so the first window after reset is judged against a previous centre and edge of 0.
- R8: For a random bit stream whose edge samples land after the true bit boundary (lagging clock), every window reports a non-negative error equal to its transition count. When they land before the boundary (leading clock), every window reports the negated count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow (quarter-rate) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samples_i | input | 2*LANES | Window of samples; even index = bit centre, odd index = boundary after that bit |
| data_o | output | LANES | Retimed parallel data, bit 0 earliest |
| err_o | output | ERR_W | Signed net phase error (late minus early) |
| up_o | output | 1 | Net error positive (clock late) |
| dn_o | output | 1 | Net error negative (clock early) |

## Verification
The assertions take for granted that a new, complete window arrives on every slow-clock edge and that the even/odd sample layout holds. They do not assume that the samples describe a physically consistent stream. The bench drives one window per cycle, changing it only at the falling edge. It uses hand-built windows for the rule and boundary cases and ideal streams, built from a shift-register sequence with a fixed lagging or leading edge offset, for the tracking cases. The first window of each stream is left unchecked, because it is judged against whatever the boundary register held before the stream began.

// File: rtl/qpd_pkg.sv
// Package: shared types for the quarter-rate phase detector.
// Assumes: nothing; holds only the per-edge vote encoding.
package qpd_pkg;

    // Decision taken at one candidate data edge.
    typedef enum logic [1:0] {
        VOTE_NONE  = 2'b00,
        VOTE_LATE  = 2'b01,
        VOTE_EARLY = 2'b10
    } vote_t;

endpackage

// File: rtl/qpd_boundary.sv
// Module: qpd_boundary
// Keeps the last centre sample and the last edge sample of the previous
// window so that the edge which straddles two windows can be judged.
// Assumes: one full window is presented on every clock edge.
module qpd_boundary #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LANES-1:0] samples_i,
    output logic               last_d_o,
    output logic               last_e_o
);
    localparam int LAST_D = 2*LANES - 2;
    localparam int LAST_E = 2*LANES - 1;

    // Capture the tail of the current window for use in the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_d_o <= 1'b0;
            last_e_o <= 1'b0;
        end else begin
            last_d_o <= samples_i[LAST_D];
            last_e_o <= samples_i[LAST_E];
        end
    end

    // R3: the held centre and edge samples are those of the previous window
    p_hold_last_r3: assert property (@(posedge clk)
        rst_n |=> (last_d_o == $past(samples_i[LAST_D])) &&
                  (last_e_o == $past(samples_i[LAST_E])));

    // R7: reset clears the boundary samples
    p_bound_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!last_d_o && !last_e_o));

endmodule

// File: rtl/qpd_edge_vote.sv
// Module: qpd_edge_vote
// Judges one candidate data edge from the centre sample before it, the
// sample taken near the boundary, and the centre sample after it.
// Assumes: the three samples belong to consecutive sampling phases.
module qpd_edge_vote
    import qpd_pkg::*;
(
    input  logic  d_lo_i,
    input  logic  e_mid_i,
    input  logic  d_hi_i,
    output vote_t vote_o
);
    // Early/late decision: the boundary sample shows which side it fell on.
    always_comb begin
        if (d_lo_i == d_hi_i)
            vote_o = VOTE_NONE;
        else if (e_mid_i != d_lo_i)
            vote_o = VOTE_LATE;
        else
            vote_o = VOTE_EARLY;
    end

endmodule

// File: rtl/qpd_vote_sum.sv
// Module: qpd_vote_sum
// Adds the per-edge votes of one window into a signed net error.
// Assumes: ERR_W is wide enough for the range -LANES..+LANES.
module qpd_vote_sum
    import qpd_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ERR_W = 4
) (
    input  logic [2*LANES-1:0]       votes_i,
    output logic signed [ERR_W-1:0]  sum_o
);
    // Count late votes up and early votes down.
    always_comb begin
        int acc;
        acc = 0;
        for (int j = 0; j < LANES; j++) begin
            case (vote_t'(votes_i[2*j +: 2]))
                VOTE_LATE:  acc = acc + 1;
                VOTE_EARLY: acc = acc - 1;
                default:    acc = acc;
            endcase
        end
        sum_o = ERR_W'(acc);
    end

endmodule

// File: rtl/qpd_top.sv
// Module: qpd_top
// Quarter-rate bang-bang phase detector with 1:4 demultiplexer. Each clock
// takes 2*LANES interleaved samples (even = bit centre, odd = boundary
// after that bit). It registers the centre bits as parallel data and the
// net early/late vote as a signed error plus up/down flags.
// Assumes: a full window arrives on every clock edge; bit 0 is the earliest.
module qpd_top
    import qpd_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ERR_W = $clog2(LANES + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*LANES-1:0]       samples_i,
    output logic [LANES-1:0]         data_o,
    output logic signed [ERR_W-1:0]  err_o,
    output logic                     up_o,
    output logic                     dn_o
);
    localparam int EXT_W = 2*LANES + 2;

    logic                    last_d;
    logic                    last_e;
    logic [EXT_W-1:0]        ext;
    logic [LANES-1:0]        centers;
    logic [2*LANES-1:0]      votes;
    logic signed [ERR_W-1:0] net;

    qpd_boundary #(.LANES(LANES)) u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (samples_i),
        .last_d_o  (last_d),
        .last_e_o  (last_e)
    );

    // Extended window: held tail of the previous window, then the new one.
    always_comb ext = {samples_i, last_e, last_d};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Pick out the centre sample of bit g.
            always_comb centers[g] = samples_i[2*g];

            vote_t v;
            qpd_edge_vote u_vote (
                .d_lo_i  (ext[2*g]),
                .e_mid_i (ext[2*g+1]),
                .d_hi_i  (ext[2*g+2]),
                .vote_o  (v)
            );
            // Pack the vote into the flat vote vector.
            always_comb votes[2*g +: 2] = v;
        end
    endgenerate

    qpd_vote_sum #(.LANES(LANES), .ERR_W(ERR_W)) u_sum (
        .votes_i (votes),
        .sum_o   (net)
    );

    // Output registers: one cycle of latency for data, error and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            err_o  <= '0;
            up_o   <= 1'b0;
            dn_o   <= 1'b0;
        end else begin
            data_o <= centers;
            err_o  <= net;
            up_o   <= (net > 0);
            dn_o   <= (net < 0);
        end
    end

    // R1: data word is the previous window's centre samples
    p_data_lat_r1: assert property (@(posedge clk)
        rst_n |=> (data_o == $past(centers)));

    // R4: net error stays within -LANES..+LANES
    p_err_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(err_o) <= LANES) && (int'(err_o) >= -LANES));

    // R5: a window without any transition yields zero error
    p_quiet_zero_r5: assert property (@(posedge clk)
        (rst_n && (centers == {LANES{last_d}})) |=> (err_o == '0));

    // R6: flags are exclusive and agree with the error sign
    p_updn_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));
    p_up_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_o |-> (err_o > 0));
    p_dn_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_o |-> (err_o < 0));

    // R7: reset clears every output
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> ((data_o == '0) && (err_o == '0) && !up_o && !dn_o));

endmodule

// File: tb/sim_qpd_top.sv
`timescale 1ns/1ps
module sim_qpd_top;
    localparam int LANES = 4;
    localparam int ERR_W = 4;
    localparam int NW    = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [2*LANES-1:0]      samples = '0;
    logic [LANES-1:0]        data;
    logic signed [ERR_W-1:0] err;
    logic                    up;
    logic                    dn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic bits [0:4*NW];

    qpd_top #(.LANES(LANES), .ERR_W(ERR_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (samples),
        .data_o    (data),
        .err_o     (err),
        .up_o      (up),
        .dn_o      (dn)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one window at a falling edge; results are visible one edge later.
    task automatic apply(input logic [2*LANES-1:0] v);
        samples = v;
        @(negedge clk);
    endtask

    task automatic chk_err(input string req, input int exp);
        chk(req, int'(err), exp);
        chk({req, " up (R6)"}, int'(up), (exp > 0) ? 1 : 0);
        chk({req, " dn (R6)"}, int'(dn), (exp < 0) ? 1 : 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(8'hFF);
        apply(8'h5A);
        chk("R7 data", int'(data), 0);
        chk_err("R7 err", 0);
        rst_n = 1'b1;
    endtask

    task automatic t_demux;
        apply(8'h00);
        apply(8'h01); chk("R1 data 01", int'(data), 4'b0001);
        apply(8'h44); chk("R1 data 44", int'(data), 4'b1010);
        apply(8'hAA); chk("R1 data AA", int'(data), 4'b0000);
        apply(8'h55); chk("R1 data 55", int'(data), 4'b1111);
    endtask

    task automatic t_rule;
        apply(8'h00);                     // prime: held centre 0, edge 0
        apply(8'hFE); chk_err("R2 late interior", 1);
        apply(8'h03); chk_err("R2 early interior", -1);
        apply(8'hFF); chk_err("R3 boundary early", -1);
        apply(8'h7F); chk_err("R5 steady ones", 0);
        apply(8'h00); chk_err("R3 boundary late", 1);
        apply(8'h80); chk_err("R5 steady zeros", 0);
        apply(8'h19); chk_err("R4 max late", 4);
        apply(8'h33); chk_err("R4 max early", -4);
        apply(8'hAA); chk_err("R5 noisy edges no transition", 0);
    endtask

    task automatic t_reset_boundary;
        apply(8'hFF);                     // held centre would be 1
        rst_n = 1'b0;
        apply(8'hFF);
        rst_n = 1'b1;
        apply(8'h03);                     // held centre 0 after reset
        chk_err("R7 boundary cleared", -2);
    endtask

    // mode 0: lagging clock, 1: leading clock, 2: constant ones
    task automatic t_stream(input int mode);
        logic [14:0] lfsr;
        int total;
        lfsr = 15'h1ACE + 15'(mode);
        total = 0;
        for (int i = 0; i <= 4*NW; i++) begin
            bits[i] = (mode == 2) ? 1'b1 : lfsr[0];
            lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
        end
        for (int w = 0; w < NW; w++) begin
            logic [2*LANES-1:0] v;
            int trans;
            int exp;
            for (int k = 0; k < LANES; k++) begin
                v[2*k]   = bits[4*w+k];
                v[2*k+1] = (mode == 1) ? bits[4*w+k] : bits[4*w+k+1];
            end
            apply(v);
            if (w > 0) begin
                trans = 0;
                for (int k = 0; k < LANES; k++)
                    if (bits[4*w+k-1] != bits[4*w+k]) trans++;
                exp = (mode == 0) ? trans : ((mode == 1) ? -trans : 0);
                total += int'(err);
                chk((mode == 2) ? "R5 constant err" : "R8 stream err", int'(err), exp);
                chk("R1 stream data", int'(data),
                    int'({bits[4*w+3], bits[4*w+2], bits[4*w+1], bits[4*w]}));
            end
        end
        if (mode == 0) chk("R8 lag total positive", int'(total > 0), 1);
        if (mode == 1) chk("R8 lead total negative", int'(total < 0), 1);
        if (mode == 2) chk("R5 constant total", total, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_demux;
        t_rule;
        t_reset_boundary;
        t_stream(0);
        t_stream(1);
        t_stream(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule